// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts activity for profiling. It has one free-running cycle counter and six event counters. Each event counter watches one line of a 32-bit event input vector, chosen by an event number that software programs. The counters are reached over a small register bus that has an address, a write strobe, write data and registered read data. Software starts and stops counters with bitmap registers, one that sets enable bits and one that clears them. It can zero the event counters or the cycle counter with self-clearing control bits. It finds wraparound in a sticky status bitmap and clears that bitmap by writing ones.

The event counters are not mapped one by one. Software first writes a select register. A single event-number window and a single count window then act on the counter that is selected. The cycle counter can be slowed by a prescaler so that it advances once every 64 clocks, which lets long intervals be measured. Every bitmap uses the same layout: bits 0 to 5 stand for event counters 0 to 5, bit 31 stands for the cycle counter, and the other bits are ignored.

Top module: `perf_mon_unit`

## Requirements
- R1: The unit holds six event counters and one cycle counter, each CNT_W bits wide (32 by default). Reads return the value zero-extended to 32 bits. With the prescaler off, the cycle counter rises by one on every clock edge at which both the unit and bitmap bit 31 are enabled.
- R2: Every bitmap register uses bit i (i = 0..5) for event counter i and bit 31 for the cycle counter. Bits 6 to 30 are never stored and always read 0.
- R3: A write to ENA_SET (address 1) enables each counter whose bit is 1. A write to ENA_CLR (address 2) disables each counter whose bit is 1. Zero bits change nothing, and both addresses read back the current enable mask.
- R4: Control bit 0 (CTRL, address 0) is the global enable. While it is 0, no counter changes value, whatever its own enable bit says.
- R5: Writing CTRL with bit 1 set zeroes every event counter. Writing CTRL with bit 2 set zeroes the cycle counter and its prescaler. Bits 1 and 2 always read back as 0, while bits 0 and 3 read back as written.
- R6: When CTRL bit 3 is 1, the cycle counter advances once every 64 enabled clock edges instead of on every edge.
- R7: The select register (SEL, address 6) keeps the low 5 bits of the value written. EVTYPE (address 7) writes and reads the event number of the selected counter, and EVCNT (address 8) reads its count. When SEL is above 5, EVCNT and EVTYPE read 0 and EVTYPE writes are ignored.
- R8: An event counter whose event number n is in 0..31 rises by one on every enabled clock edge at which evt_in[n] is 1. Event numbers are 8 bits wide.
- R9: An event counter programmed with an event number of 32 or more never increments, and EVCNT reads 0 for it.
- R10: When a counter wraps from all ones to zero, its bit in OVF (address 3) is set. Writing ones to OVF clears the matching bits. If a set and a clear hit the same bit on the same edge, the set wins.
- R11: IRQ_SET (address 4) and IRQ_CLR (address 5) set and clear bits of an overflow-report enable mask, in the same way as R3. Both addresses read back the mask.
- R12: Read data is registered. bus_rdata shows, one clock after the edge, the register selected by bus_addr as it was before that edge. Unused addresses read 0, and the cycle count is read at CYCCNT (address 9). Everything resets to 0 on a synchronous active-high reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | EVT_IN_W (32) | Event pulse vector, sampled every clock |

## Verification
A counter that takes a wrong step, or a gating term that is wrong, shows up as a wrong count. That count appears at bus_rdata one clock after the counter is read, and from then on it stays wrong. A wrong enable bit, overflow bit or select value shows up on the next read of the matching bitmap, or as counts that stop or run on when they should not. The bench's reference model predicts bus_rdata on every edge. A fault that is visible at the ports is therefore seen in the cycle it first appears on the bus. Long runs with random events, with all events high and with single events then cover gating, wraparound and the prescaler.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned REG_ADDR_W = 4;
  localparam int unsigned SEL_W      = 5;
  localparam int unsigned CYC_BIT    = 31;

  // register word addresses
  localparam logic [REG_ADDR_W-1:0] RA_CTRL    = 4'd0;
  localparam logic [REG_ADDR_W-1:0] RA_ENA_SET = 4'd1;
  localparam logic [REG_ADDR_W-1:0] RA_ENA_CLR = 4'd2;
  localparam logic [REG_ADDR_W-1:0] RA_OVF     = 4'd3;
  localparam logic [REG_ADDR_W-1:0] RA_IRQ_SET = 4'd4;
  localparam logic [REG_ADDR_W-1:0] RA_IRQ_CLR = 4'd5;
  localparam logic [REG_ADDR_W-1:0] RA_SEL     = 4'd6;
  localparam logic [REG_ADDR_W-1:0] RA_EVTYPE  = 4'd7;
  localparam logic [REG_ADDR_W-1:0] RA_EVCNT   = 4'd8;
  localparam logic [REG_ADDR_W-1:0] RA_CYCCNT  = 4'd9;

  // control bit positions
  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_EVRST = 1;
  localparam int unsigned CB_CYRST = 2;
  localparam int unsigned CB_DIV   = 3;
endpackage

// File: rtl/pmu_bitmap_reg.sv
module pmu_bitmap_reg #(
  parameter int NUM_EVT = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  output logic [31:0] mask
);
  localparam logic [31:0] VALID = {1'b1, {(31-NUM_EVT){1'b0}}, {NUM_EVT{1'b1}}};

  logic [31:0] wsel;
  assign wsel = wdata & VALID;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (set_we) begin
      mask <= mask | wsel;
    end else if (clr_we) begin
      mask <= mask & ~wsel;
    end
  end
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int CNT_W    = 32,
  parameter int EVT_IN_W = 32,
  parameter int TYPE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                run,
  input  logic                type_we,
  input  logic [TYPE_W-1:0]   type_wd,
  input  logic [EVT_IN_W-1:0] evt_in,
  output logic [CNT_W-1:0]    cnt,
  output logic [TYPE_W-1:0]   evt_type,
  output logic                supported,
  output logic                wrap
);
  localparam int IDX_W = $clog2(EVT_IN_W);

  logic hit;
  logic step;

  assign supported = (evt_type < TYPE_W'(EVT_IN_W));
  assign hit       = supported && evt_in[evt_type[IDX_W-1:0]];
  assign step      = run && hit && !clr;
  assign wrap      = step && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      evt_type <= '0;
    end else begin
      if (clr) begin
        cnt <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
      end
      if (type_we) begin
        evt_type <= type_wd;
      end
    end
  end
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             div_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [DIV_LOG2-1:0] pre;
  logic                tick;

  assign tick = run && !clr && (!div_en || (&pre));
  assign wrap = tick && (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      pre <= '0;
    end else begin
      if (run && div_en) begin
        pre <= pre + 1'b1;
      end
      if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 6,
  parameter int CNT_W    = 32,
  parameter int EVT_IN_W = 32,
  parameter int TYPE_W   = 8,
  parameter int DIV_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [EVT_IN_W-1:0]   evt_in
);
  localparam int PAD_W = 31 - NUM_EVT;

  // bus decode
  logic wr_ctrl, wr_ena_set, wr_ena_clr, wr_ovf, wr_irq_set, wr_irq_clr, wr_sel, wr_type;
  assign wr_ctrl    = bus_wr && (bus_addr == RA_CTRL);
  assign wr_ena_set = bus_wr && (bus_addr == RA_ENA_SET);
  assign wr_ena_clr = bus_wr && (bus_addr == RA_ENA_CLR);
  assign wr_ovf     = bus_wr && (bus_addr == RA_OVF);
  assign wr_irq_set = bus_wr && (bus_addr == RA_IRQ_SET);
  assign wr_irq_clr = bus_wr && (bus_addr == RA_IRQ_CLR);
  assign wr_sel     = bus_wr && (bus_addr == RA_SEL);
  assign wr_type    = bus_wr && (bus_addr == RA_EVTYPE);

  logic evt_rst, cyc_rst;
  assign evt_rst = wr_ctrl && bus_wdata[CB_EVRST];
  assign cyc_rst = wr_ctrl && bus_wdata[CB_CYRST];

  // control and select
  logic             glb_en, div_en;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en <= 1'b0;
      div_en <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        glb_en <= bus_wdata[CB_EN];
        div_en <= bus_wdata[CB_DIV];
      end
      if (wr_sel) begin
        sel_q <= bus_wdata[SEL_W-1:0];
      end
    end
  end

  // bitmaps
  logic [31:0] ena_mask, irq_mask;

  pmu_bitmap_reg #(.NUM_EVT(NUM_EVT)) u_ena (
    .clk(clk), .rst(rst), .set_we(wr_ena_set), .clr_we(wr_ena_clr),
    .wdata(bus_wdata), .mask(ena_mask)
  );

  pmu_bitmap_reg #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk(clk), .rst(rst), .set_we(wr_irq_set), .clr_we(wr_irq_clr),
    .wdata(bus_wdata), .mask(irq_mask)
  );

  // event counters
  logic [CNT_W-1:0]         evt_cnt  [NUM_EVT];
  logic [TYPE_W-1:0]        evt_type [NUM_EVT];
  logic [NUM_EVT-1:0]       evt_sup;
  logic [NUM_EVT-1:0]       evt_wrap;
  logic [NUM_EVT*CNT_W-1:0] evt_cnt_flat;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic type_we_g;
    assign type_we_g = wr_type && (sel_q == SEL_W'(g));

    pmu_evt_counter #(
      .CNT_W(CNT_W), .EVT_IN_W(EVT_IN_W), .TYPE_W(TYPE_W)
    ) u_cnt (
      .clk(clk), .rst(rst), .clr(evt_rst),
      .run(glb_en && ena_mask[g]),
      .type_we(type_we_g), .type_wd(bus_wdata[TYPE_W-1:0]),
      .evt_in(evt_in),
      .cnt(evt_cnt[g]), .evt_type(evt_type[g]),
      .supported(evt_sup[g]), .wrap(evt_wrap[g])
    );

    assign evt_cnt_flat[g*CNT_W +: CNT_W] = evt_cnt[g];
  end

  // cycle counter
  logic [CNT_W-1:0] cyc_cnt;
  logic             cyc_wrap;

  pmu_cyc_counter #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_cyc (
    .clk(clk), .rst(rst), .clr(cyc_rst),
    .run(glb_en && ena_mask[CYC_BIT]),
    .div_en(div_en), .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  // overflow status, set wins over clear
  logic [31:0] wrap_vec, ovf_q, ovf_clr;
  assign wrap_vec = {cyc_wrap, {PAD_W{1'b0}}, evt_wrap};
  assign ovf_clr  = wr_ovf ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
    end
  end

  // indirect window
  logic              sel_ok;
  logic [CNT_W-1:0]  sel_cnt;
  logic [TYPE_W-1:0] sel_type;
  assign sel_ok = (sel_q < SEL_W'(NUM_EVT));

  always_comb begin
    sel_cnt  = '0;
    sel_type = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_ok && (sel_q == SEL_W'(i))) begin
        sel_type = evt_type[i];
        if (evt_sup[i]) begin
          sel_cnt = evt_cnt[i];
        end
      end
    end
  end

  // registered read port
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (bus_addr)
      RA_CTRL:    rd_next = {28'd0, div_en, 2'b00, glb_en};
      RA_ENA_SET,
      RA_ENA_CLR: rd_next = ena_mask;
      RA_OVF:     rd_next = ovf_q;
      RA_IRQ_SET,
      RA_IRQ_CLR: rd_next = irq_mask;
      RA_SEL:     rd_next = DATA_W'(sel_q);
      RA_EVTYPE:  rd_next = DATA_W'(sel_type);
      RA_EVCNT:   rd_next = DATA_W'(sel_cnt);
      RA_CYCCNT:  rd_next = DATA_W'(cyc_cnt);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pmu_checks.sv
module pmu_checks
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 6,
  parameter int CNT_W   = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  glb_en,
  input logic [31:0]           ena_mask,
  input logic [NUM_EVT*CNT_W-1:0] evt_cnt_flat,
  input logic [CNT_W-1:0]      cyc_cnt,
  input logic [31:0]           ovf_q,
  input logic [31:0]           wrap_vec
);
  localparam logic [31:0] VALID = {1'b1, {(31-NUM_EVT){1'b0}}, {NUM_EVT{1'b1}}};

  logic c_ctrl, c_set, c_clr;
  assign c_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign c_set  = bus_wr && (bus_addr == RA_ENA_SET);
  assign c_clr  = bus_wr && (bus_addr == RA_ENA_CLR);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !c_ctrl) |=> ($stable(evt_cnt_flat) && $stable(cyc_cnt))); // R4

  AST_ENA_SET: assert property (@(posedge clk) disable iff (rst)
    c_set |=> ((ena_mask & $past(bus_wdata & VALID)) == $past(bus_wdata & VALID))); // R3

  AST_ENA_CLR: assert property (@(posedge clk) disable iff (rst)
    c_clr |=> ((ena_mask & $past(bus_wdata)) == 32'd0)); // R3

  AST_EVT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (c_ctrl && bus_wdata[CB_EVRST]) |=> (evt_cnt_flat == '0)); // R5

  AST_CYC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (c_ctrl && bus_wdata[CB_CYRST]) |=> (cyc_cnt == '0)); // R5

  AST_OVF_STICK: assert property (@(posedge clk) disable iff (rst)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec))); // R10

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    !c_ctrl |=> ((cyc_cnt == $past(cyc_cnt)) || (cyc_cnt == CNT_W'($past(cyc_cnt) + 1'b1)))); // R1
endmodule

bind perf_mon_unit pmu_checks #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .glb_en(glb_en), .ena_mask(ena_mask), .evt_cnt_flat(evt_cnt_flat),
  .cyc_cnt(cyc_cnt), .ovf_q(ovf_q), .wrap_vec(wrap_vec)
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  localparam int CW  = 12;
  localparam int MAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_in = '0;

  always #2 clk = ~clk;

  perf_mon_unit #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // event stimulus
  int          evt_mode = 0;
  logic [31:0] evt_manual = '0;
  logic [31:0] lfsr = 32'hACE1_2468;
  always @(negedge clk) begin
    case (evt_mode)
      1: begin
        lfsr   = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        evt_in = lfsr;
      end
      2: evt_in = '1;
      3: evt_in = evt_manual;
      default: evt_in = '0;
    endcase
  end

  // behavioural reference model
  bit          m_en, m_div;
  logic [31:0] m_ena, m_irq, m_ovf;
  int          m_sel;
  int          m_type [6];
  int          m_cnt  [6];
  int          m_cyc, m_pre;
  logic [31:0] exp_rd = '0;
  logic [3:0]  last_addr = '0;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {28'd0, m_div, 2'b00, m_en};
      4'd1, 4'd2: return m_ena;
      4'd3: return m_ovf;
      4'd4, 4'd5: return m_irq;
      4'd6: return 32'(m_sel);
      4'd7: return (m_sel < 6) ? 32'(m_type[m_sel]) : 32'd0;
      4'd8: return (m_sel < 6 && m_type[m_sel] < 32) ? 32'(m_cnt[m_sel]) : 32'd0;
      4'd9: return 32'(m_cyc);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R5";
      4'd1, 4'd2: return "R3";
      4'd3: return "R10";
      4'd4, 4'd5: return "R11";
      4'd6, 4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R1";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_div = 0; m_ena = '0; m_irq = '0; m_ovf = '0; m_sel = 0;
      m_cyc = 0; m_pre = 0; exp_rd = '0;
      for (int i = 0; i < 6; i++) begin m_type[i] = 0; m_cnt[i] = 0; end
    end else begin
      logic [31:0] wrapv;
      logic [31:0] vw;
      bit evr, cyr;
      exp_rd    = m_read(bus_addr);
      last_addr = bus_addr;
      wrapv = '0;
      vw    = bus_wdata & 32'h8000_003F;
      evr = bus_wr && bus_addr == 4'd0 && bus_wdata[1];
      cyr = bus_wr && bus_addr == 4'd0 && bus_wdata[2];
      for (int i = 0; i < 6; i++) begin
        if (evr) m_cnt[i] = 0;
        else if (m_en && m_ena[i] && m_type[i] < 32 && evt_in[m_type[i]]) begin
          if (m_cnt[i] == MAX) begin m_cnt[i] = 0; wrapv[i] = 1'b1; end
          else m_cnt[i]++;
        end
      end
      if (cyr) begin
        m_cyc = 0; m_pre = 0;
      end else if (m_en && m_ena[31]) begin
        bit t;
        t = 1'b1;
        if (m_div) begin
          t = (m_pre == 63);
          m_pre = (m_pre + 1) % 64;
        end
        if (t) begin
          if (m_cyc == MAX) begin m_cyc = 0; wrapv[31] = 1'b1; end
          else m_cyc++;
        end
      end
      if (bus_wr && bus_addr == 4'd3) m_ovf = m_ovf & ~bus_wdata;
      m_ovf = m_ovf | wrapv;
      if (bus_wr) begin
        case (bus_addr)
          4'd0: begin m_en = bus_wdata[0]; m_div = bus_wdata[3]; end
          4'd1: m_ena = m_ena | vw;
          4'd2: m_ena = m_ena & ~vw;
          4'd4: m_irq = m_irq | vw;
          4'd5: m_irq = m_irq & ~vw;
          4'd6: m_sel = int'(bus_wdata[4:0]);
          4'd7: if (m_sel < 6) m_type[m_sel] = int'(bus_wdata[7:0]);
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model (R12 read latency)
  bit started = 1'b0;
  always @(negedge clk) begin
    if (!rst && started && !done) chk(bus_rdata == exp_rd, tag_of(last_addr), bus_rdata, exp_rd);
    if (!rst) started = 1'b1;
  end

  // bus tasks: each starts and ends at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int tlist [6] = '{0, 5, 31, 40, 2, 7};

  initial begin : main
    logic [31:0] v, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(4'd0, v);  chk(v == 0, "R12 reset ctrl", v, 0);
    rd(4'd1, v);  chk(v == 0, "R12 reset ena", v, 0);
    rd(4'd9, v);  chk(v == 0, "R1 reset cycle count", v, 0);

    for (int i = 0; i < 6; i++) begin
      wr(4'd6, 32'(i));
      wr(4'd7, 32'(tlist[i]));
    end

    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v);  chk(v == 32'h8000_003F, "R2 enable layout", v, 32'h8000_003F);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd5, 32'h0000_0003);
    rd(4'd5, v);  chk(v == 32'h8000_003C, "R11 irq mask", v, 32'h8000_003C);

    // run with random events
    wr(4'd0, 32'h7);
    rd(4'd0, v);  chk(v == 32'h1, "R5 self-clearing bits", v, 32'h1);
    evt_mode = 1;
    idle(200);
    wr(4'd0, 32'h0);
    evt_mode = 0;
    rd(4'd9, v);  chk(v == 202, "R1 cycle count", v, 202);
    for (int i = 0; i < 6; i++) begin
      wr(4'd6, 32'(i));
      rd(4'd8, v);
    end
    wr(4'd6, 32'd3);
    rd(4'd7, v);  chk(v == 40, "R7 type readback", v, 40);
    rd(4'd8, v);  chk(v == 0, "R9 unsupported reads zero", v, 0);

    // global gate
    evt_mode = 2;
    wr(4'd6, 32'd0);
    rd(4'd8, v);
    idle(20);
    rd(4'd8, v2); chk(v2 == v, "R4 no count while disabled", v2, v);
    rd(4'd9, v2); chk(v2 == 202, "R4 cycle held", v2, 202);

    // individual disable
    wr(4'd2, 32'h1);
    wr(4'd0, 32'h1);
    idle(50);
    wr(4'd0, 32'h0);
    rd(4'd8, v2); chk(v2 == v, "R3 cleared counter frozen", v2, v);
    wr(4'd1, 32'h1);

    // out-of-range select
    wr(4'd6, 32'd7);
    rd(4'd8, v);  chk(v == 0, "R7 count at sel 7", v, 0);
    wr(4'd7, 32'd3);
    rd(4'd7, v);  chk(v == 0, "R7 type at sel 7", v, 0);
    wr(4'd6, 32'd0);
    rd(4'd7, v);  chk(v == 0, "R7 ignored type write", v, 0);

    // prescaler
    evt_mode = 0;
    wr(4'd0, 32'hD);
    idle(129);
    wr(4'd0, 32'h0);
    rd(4'd9, v);  chk(v == 2, "R6 prescaled cycle count", v, 2);

    // wraparound
    wr(4'd3, 32'hFFFF_FFFF);
    evt_mode = 2;
    wr(4'd0, 32'h7);
    idle(4200);
    wr(4'd0, 32'h0);
    rd(4'd3, v);  chk(v == 32'h8000_0037, "R10 overflow set", v, 32'h8000_0037);
    wr(4'd3, 32'h1);
    rd(4'd3, v);  chk(v == 32'h8000_0036, "R10 partial clear", v, 32'h8000_0036);
    wr(4'd3, 32'h8000_0037);
    rd(4'd3, v);  chk(v == 0, "R10 full clear", v, 0);

    // single event line
    wr(4'd0, 32'h2);
    evt_manual = 32'h0000_0020;
    evt_mode = 3;
    idle(1);
    wr(4'd0, 32'h1);
    idle(9);
    wr(4'd0, 32'h0);
    wr(4'd6, 32'd1);
    rd(4'd8, v);  chk(v == 10, "R8 selected line counts", v, 10);
    wr(4'd6, 32'd0);
    rd(4'd8, v);  chk(v == 0, "R8 other line quiet", v, 0);
    wr(4'd6, 32'd5);
    rd(4'd8, v);  chk(v == 0, "R8 line 7 quiet", v, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule